// File: doc/BRIEF.md
# Expansion Card Configuration Responder

This block lets an expansion card on a 68000-style bus take part in the power-up configuration sequence. While it has no address yet and its chain-enable input is low, it answers reads in the configuration page with its identity, one nibble per word on the upper four data lines. The host reads the identity, writes a base address one nibble at a time, and the card then releases its chain-enable output so the next card in the chain can be configured. After that the card decodes its own address window and no longer answers in the configuration page.

The host may instead send a shut-up write. The card then releases the chain but never decodes a window. The host supplies every bit of the base address, so the card can be placed in the memory region when the I/O region is full. A build-time switch selects a 64 KB board in place of the default 128 KB board. The switch changes both the size code the card reports and how many address bits its window compares.

Top module: `acfg_responder`

## Requirements
- R1: After reset the chain output `cfg_out_n` is high, `slave_n` is high, `card_sel` is low and `rdata` is zero. The handshake outputs `dtack_n` and `ovr_n` are always high.
- R2: A read in the configuration page returns a nibble on `rdata[15:12]`. The read needs `as_n` low, `rw` high, `cfg_in_n` low, the card unconfigured, `addr[23:16]` equal to `CFG_PAGE` and `addr[15:7]` zero. Slot `addr[6:2]` selects a byte, and `addr[1]` = 0 gives its high nibble. The slots are 0 type, 1 product, 2 flags (0x00), 4 and 5 maker high and low, and 6 to 9 serial with the most significant byte first. Every other slot holds 0x00. The type byte is returned as stored and every other byte is returned inverted. During such a read `slave_n` is low and `rdata[11:0]` is zero.
- R3: The type byte is 0xC0 OR the size code. The size code is 3'b010 for the default 128 KB board and 3'b001 when `BOARD_64K`=1.
- R4: While `cfg_in_n` is high the card does not answer: `slave_n` stays high and `rdata` stays zero. Writes made while `cfg_in_n` is high have no effect.
- R5: A configuration write needs `rw` low and `uds_n` low, and takes its data from `wnib`. A write at offset 0x4A (slot 18, `addr[1]`=1) stores base bits 3:0. A write at offset 0x48 (slot 18, `addr[1]`=0) stores base bits 7:4 and marks the card configured. From the clock edge that samples that write, `cfg_out_n` is low.
- R6: Every base bit comes from the host, including values outside the I/O page.
- R7: Once configured, `card_sel` is high and `slave_n` is low whenever `as_n` is low and the address matches the base. For 128 KB the match is `addr[23:17]` against base bits 7:1. For 64 KB it is `addr[23:16]` against base bits 7:0.
- R8: While `as_n` is high, `slave_n` is high and `card_sel` is low, whatever the address.
- R9: A write at offset 0x4C (slot 19) pulls `cfg_out_n` low but enables no window. After it the card answers neither reads in the configuration page nor reads at any address.
- R10: Once configured, the card no longer answers reads in the configuration page, and its base is locked.
- R11: `cfg_in_n` is used as a level and is not latched. A change on it takes effect within the same clock cycle, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 23 | Address bus, bits 23 to 1 |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| rw | input | 1 | High for read, low for write |
| wnib | input | 4 | Upper nibble of write data |
| cfg_in_n | input | 1 | Chain enable from the previous card, active low |
| rdata | output | 16 | Read data, nibble on bits 15:12 |
| card_sel | output | 1 | Access falls in the assigned window |
| slave_n | output | 1 | Card claims the cycle, active low |
| cfg_out_n | output | 1 | Chain enable to the next card, active low |
| dtack_n | output | 1 | Data acknowledge, held inactive |
| ovr_n | output | 1 | Override, held inactive |

## Verification
The hardest case to reach is the claim that `cfg_in_n` is a level, because a latched version gives the same result at every clock edge. To expose it, the stimulus holds a configuration read with the strobe low, then changes `cfg_in_n` partway through one clock period and samples `slave_n` before the next edge. The shut-up path and the ignored write each need a fresh reset. Their effect is read back through later configuration reads and window accesses.

// File: rtl/acfg_pkg.sv
package acfg_pkg;
  localparam int ADDR_W = 24;
  localparam int BASE_W = 8;
  localparam int NIB_W  = 4;
  localparam int SLOT_W = 5;
  localparam int DATA_W = 16;

  typedef logic [SLOT_W-1:0] slot_t;

  localparam slot_t SLOT_TYPE   = 5'd0;
  localparam slot_t SLOT_PROD   = 5'd1;
  localparam slot_t SLOT_FLAGS  = 5'd2;
  localparam slot_t SLOT_MFR_HI = 5'd4;
  localparam slot_t SLOT_MFR_LO = 5'd5;
  localparam slot_t SLOT_SER_0  = 5'd6;
  localparam slot_t SLOT_SER_1  = 5'd7;
  localparam slot_t SLOT_SER_2  = 5'd8;
  localparam slot_t SLOT_SER_3  = 5'd9;
  localparam slot_t SLOT_BASE   = 5'd18;
  localparam slot_t SLOT_SHUT   = 5'd19;

  typedef enum logic [2:0] {
    SZ_8M   = 3'b000,
    SZ_64K  = 3'b001,
    SZ_128K = 3'b010
  } size_e;

  function automatic size_e size_code(input logic small_board);
    return small_board ? SZ_64K : SZ_128K;
  endfunction

  function automatic logic [7:0] type_byte(input logic small_board);
    return {2'b11, 3'b000, size_code(small_board)};
  endfunction

  function automatic logic [7:0] raw_byte(
    input slot_t       slot,
    input logic        small_board,
    input logic [7:0]  prod,
    input logic [15:0] mfr,
    input logic [31:0] serial
  );
    logic [7:0] b;
    case (slot)
      SLOT_TYPE:   b = type_byte(small_board);
      SLOT_PROD:   b = prod;
      SLOT_FLAGS:  b = 8'h00;
      SLOT_MFR_HI: b = mfr[15:8];
      SLOT_MFR_LO: b = mfr[7:0];
      SLOT_SER_0:  b = serial[31:24];
      SLOT_SER_1:  b = serial[23:16];
      SLOT_SER_2:  b = serial[15:8];
      SLOT_SER_3:  b = serial[7:0];
      default:     b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic logic [NIB_W-1:0] bus_nibble(
    input slot_t       slot,
    input logic        lo_half,
    input logic        small_board,
    input logic [7:0]  prod,
    input logic [15:0] mfr,
    input logic [31:0] serial
  );
    logic [7:0] b;
    b = raw_byte(slot, small_board, prod, mfr, serial);
    if (slot != SLOT_TYPE) b = ~b;
    return lo_half ? b[3:0] : b[7:4];
  endfunction
endpackage

// File: rtl/acfg_id_rom.sv
module acfg_id_rom
  import acfg_pkg::*;
#(
  parameter bit          BOARD_64K = 1'b0,
  parameter logic [7:0]  PROD_ID   = 8'h3C,
  parameter logic [15:0] MFR_ID    = 16'h1D4F,
  parameter logic [31:0] SERIAL    = 32'h1234_5678
) (
  input  slot_t            slot,
  input  logic             lo_half,
  output logic [NIB_W-1:0] nib
);
  always_comb begin
    nib = bus_nibble(slot, lo_half, BOARD_64K, PROD_ID, MFR_ID, SERIAL);
  end
endmodule

// File: rtl/acfg_cfg_regs.sv
module acfg_cfg_regs
  import acfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  slot_t             slot,
  input  logic              lo_half,
  input  logic [NIB_W-1:0]  wnib,
  output logic [BASE_W-1:0] base_q,
  output logic              configured_q,
  output logic              shut_q,
  output logic              wr_base_hi,
  output logic              wr_base_lo,
  output logic              wr_shut
);
  assign wr_base_lo = wr_en && (slot == SLOT_BASE) && lo_half;
  assign wr_base_hi = wr_en && (slot == SLOT_BASE) && !lo_half;
  assign wr_shut    = wr_en && (slot == SLOT_SHUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q       <= '0;
      configured_q <= 1'b0;
      shut_q       <= 1'b0;
    end else begin
      if (wr_base_lo) base_q[NIB_W-1:0] <= wnib;
      if (wr_base_hi) begin
        base_q[BASE_W-1:NIB_W] <= wnib;
        configured_q           <= 1'b1;
      end
      if (wr_shut) shut_q <= 1'b1;
    end
  end

  AST_CONFIG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(configured_q) |-> configured_q); // R10
  AST_BASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(configured_q) && configured_q) |-> $stable(base_q)); // R10
  AST_HI_CONFIGURES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base_hi |=> configured_q); // R5
  AST_SHUT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_shut |=> (shut_q && $stable(configured_q))); // R9
endmodule

// File: rtl/acfg_window_dec.sv
module acfg_window_dec
  import acfg_pkg::*;
#(
  parameter bit         BOARD_64K = 1'b0,
  parameter logic [7:0] CFG_PAGE  = 8'hE8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:7] addr,
  input  logic              as_n,
  input  logic              cfg_in_n,
  input  logic              configured,
  input  logic              shut,
  input  logic [BASE_W-1:0] base,
  output logic              cfg_hit,
  output logic              card_sel
);
  localparam int WIN_LSB  = BOARD_64K ? 16 : 17;
  localparam int WIN_BITS = ADDR_W - WIN_LSB;

  logic page_hit;
  logic win_match;

  assign page_hit = (addr[ADDR_W-1:16] == CFG_PAGE) && (addr[15:7] == '0);

  generate
    if (BOARD_64K) begin : g_win64
      assign win_match = (addr[ADDR_W-1:16] == base);
    end else begin : g_win128
      assign win_match = (addr[ADDR_W-1:WIN_LSB] == base[BASE_W-1:BASE_W-WIN_BITS]);
    end
  endgenerate

  assign cfg_hit  = !as_n && !cfg_in_n && !configured && !shut && page_hit;
  assign card_sel = !as_n && configured && !shut && win_match;

  AST_CFG_NEEDS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |-> !cfg_in_n); // R4
  AST_NO_SEL_UNCONF: assert property (@(posedge clk) disable iff (!rst_n)
    !configured |-> !card_sel); // R7
endmodule

// File: rtl/acfg_responder.sv
module acfg_responder
  import acfg_pkg::*;
#(
  parameter bit          BOARD_64K = 1'b0,
  parameter logic [7:0]  CFG_PAGE  = 8'hE8,
  parameter logic [7:0]  PROD_ID   = 8'h3C,
  parameter logic [15:0] MFR_ID    = 16'h1D4F,
  parameter logic [31:0] SERIAL    = 32'h1234_5678
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:1] addr,
  input  logic              as_n,
  input  logic              uds_n,
  input  logic              rw,
  input  logic [NIB_W-1:0]  wnib,
  input  logic              cfg_in_n,
  output logic [DATA_W-1:0] rdata,
  output logic              card_sel,
  output logic              slave_n,
  output logic              cfg_out_n,
  output logic              dtack_n,
  output logic              ovr_n
);
  slot_t             slot;
  logic              lo_half;
  logic [NIB_W-1:0]  id_nib;
  logic [BASE_W-1:0] base_q;
  logic              configured_q;
  logic              shut_q;
  logic              cfg_hit;
  logic              cfg_rd;
  logic              cfg_wr;
  logic              wr_base_hi;
  logic              wr_base_lo;
  logic              wr_shut;

  assign slot    = addr[6:2];
  assign lo_half = addr[1];
  assign cfg_rd  = cfg_hit && rw;
  assign cfg_wr  = cfg_hit && !rw && !uds_n;

  acfg_id_rom #(
    .BOARD_64K(BOARD_64K), .PROD_ID(PROD_ID), .MFR_ID(MFR_ID), .SERIAL(SERIAL)
  ) u_rom (
    .slot(slot), .lo_half(lo_half), .nib(id_nib)
  );

  acfg_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .slot(slot), .lo_half(lo_half),
    .wnib(wnib), .base_q(base_q), .configured_q(configured_q), .shut_q(shut_q),
    .wr_base_hi(wr_base_hi), .wr_base_lo(wr_base_lo), .wr_shut(wr_shut)
  );

  acfg_window_dec #(.BOARD_64K(BOARD_64K), .CFG_PAGE(CFG_PAGE)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(addr[ADDR_W-1:7]), .as_n(as_n),
    .cfg_in_n(cfg_in_n), .configured(configured_q), .shut(shut_q),
    .base(base_q), .cfg_hit(cfg_hit), .card_sel(card_sel)
  );

  assign rdata     = cfg_rd ? {id_nib, {(DATA_W-NIB_W){1'b0}}} : '0;
  assign slave_n   = !(cfg_hit || card_sel);
  assign cfg_out_n = !(configured_q || shut_q);
  assign dtack_n   = 1'b1;
  assign ovr_n     = 1'b1;

  AST_SLAVE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (slave_n && !card_sel)); // R8
  AST_CHAIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base_hi || wr_shut) |=> !cfg_out_n); // R5
  AST_CHAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_out_n) |-> !cfg_out_n); // R9
  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_hit && card_sel)); // R10
  AST_DATA_ONLY_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata != '0) |-> (cfg_hit && rw)); // R2
  AST_LO_NO_CONF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base_lo && !configured_q && !shut_q) |=> cfg_out_n); // R5
endmodule

// File: tb/acfg_responder_tb.sv
module acfg_responder_tb_top;
  localparam int CLK_P = 10;
  localparam int NRD   = 15;
  localparam logic [27:0] RD_TAB [NRD] = '{
    {24'hE80000, 4'hC}, {24'hE80002, 4'h2},
    {24'hE80004, 4'hC}, {24'hE80006, 4'h3},
    {24'hE80008, 4'hF}, {24'hE8000A, 4'hF},
    {24'hE8000C, 4'hF}, {24'hE80010, 4'hE},
    {24'hE80012, 4'h2}, {24'hE80014, 4'hB},
    {24'hE80016, 4'h0}, {24'hE80018, 4'hE},
    {24'hE8001A, 4'hD}, {24'hE80024, 4'h8},
    {24'hE80026, 4'h7}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:1] addr = '0;
  logic        as_n = 1'b1;
  logic        uds_n = 1'b1;
  logic        rw = 1'b1;
  logic [3:0]  wnib = '0;
  logic        cfg_in_n = 1'b0;
  logic [15:0] rdata, rdata64;
  logic        card_sel, card_sel64, slave_n, slave_n64;
  logic        cfg_out_n, cfg_out_n64, dtack_n, ovr_n, dtack_n64, ovr_n64;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  acfg_responder dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .as_n(as_n), .uds_n(uds_n), .rw(rw),
    .wnib(wnib), .cfg_in_n(cfg_in_n), .rdata(rdata), .card_sel(card_sel),
    .slave_n(slave_n), .cfg_out_n(cfg_out_n), .dtack_n(dtack_n), .ovr_n(ovr_n)
  );

  acfg_responder #(.BOARD_64K(1'b1)) dut64_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .as_n(as_n), .uds_n(uds_n), .rw(rw),
    .wnib(wnib), .cfg_in_n(cfg_in_n), .rdata(rdata64), .card_sel(card_sel64),
    .slave_n(slave_n64), .cfg_out_n(cfg_out_n64), .dtack_n(dtack_n64), .ovr_n(ovr_n64)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    as_n = 1'b1; uds_n = 1'b1; rw = 1'b1; addr = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; as_n = 1'b1; uds_n = 1'b1; rw = 1'b1; cfg_in_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_read(input logic [23:0] a);
    @(negedge clk);
    addr = a[23:1]; rw = 1'b1; as_n = 1'b0; uds_n = 1'b0;
    #1;
  endtask

  task automatic bus_write(input logic [23:0] a, input logic [3:0] n);
    @(negedge clk);
    addr = a[23:1]; rw = 1'b0; as_n = 1'b0; uds_n = 1'b0; wnib = n;
    @(posedge clk);
    idle();
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    do_reset();
    #1;
    // R1 reset state
    chk("R1 cfg_out_n", cfg_out_n, 1);
    chk("R1 slave_n", slave_n, 1);
    chk("R1 card_sel", card_sel, 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 dtack_n", dtack_n, 1);
    chk("R1 ovr_n", ovr_n, 1);

    // R2 identity table
    for (int i = 0; i < NRD; i++) begin
      bus_read(RD_TAB[i][27:4]);
      chk("R2 nibble", rdata[15:12], RD_TAB[i][3:0]);
      chk("R2 low bits", rdata[11:0], 0);
      chk("R2 slave_n", slave_n, 0);
      idle();
    end

    // R3 size code in type byte
    bus_read(24'hE80002);
    chk("R3 default size", rdata[15:12], 4'h2);
    chk("R3 small size", rdata64[15:12], 4'h1);
    chk("R3 small type hi", dtack_n64 & ovr_n64, 1);
    idle();

    // R11 level-sensitive chain input, mid-cycle
    @(negedge clk);
    cfg_in_n = 1'b1; addr = 23'(24'hE80000 >> 1); rw = 1'b1; as_n = 1'b0;
    #1;
    chk("R4 no answer chain high", slave_n, 1);
    chk("R4 no data chain high", rdata, 0);
    #1 cfg_in_n = 1'b0;
    #1;
    chk("R11 answers same cycle", slave_n, 0);
    chk("R11 data same cycle", rdata[15:12], 4'hC);
    idle();

    // R4 write ignored while chain high
    cfg_in_n = 1'b1;
    bus_write(24'hE8004A, 4'h1);
    bus_write(24'hE80048, 4'h2);
    chk("R4 write ignored", cfg_out_n, 1);
    cfg_in_n = 1'b0;
    bus_read(24'hE80000);
    chk("R4 still unconfigured", slave_n, 0);
    idle();

    // R5 lo nibble alone does not configure, hi does
    bus_write(24'hE8004A, 4'h1);
    chk("R5 lo nibble keeps chain", cfg_out_n, 1);
    bus_write(24'hE80048, 4'h2);
    chk("R5 chain released", cfg_out_n, 0);
    chk("R5 chain released small", cfg_out_n64, 0);

    // R6/R7 window at base 0x21 (memory region)
    bus_read(24'h21FFFE);
    chk("R7 top of window", card_sel, 1);
    chk("R7 slave in window", slave_n, 0);
    chk("R7 small top of window", card_sel64, 1);
    idle();
    bus_read(24'h200000);
    chk("R6 full base 128k", card_sel, 1);
    chk("R7 small excludes 0x20", card_sel64, 0);
    idle();
    bus_read(24'h220000);
    chk("R7 above window", card_sel, 0);
    chk("R7 small above window", card_sel64, 0);
    idle();
    bus_read(24'h1FFFFE);
    chk("R7 below window", card_sel, 0);
    chk("R7 slave outside", slave_n, 1);
    idle();

    // R8 strobe gating
    @(negedge clk);
    addr = 23'(24'h210000 >> 1); as_n = 1'b1; rw = 1'b1;
    #1;
    chk("R8 no sel without strobe", card_sel, 0);
    chk("R8 no slave without strobe", slave_n, 1);

    // R10 config page silent after configure, base locked
    bus_read(24'hE80000);
    chk("R10 no cfg answer", slave_n, 1);
    chk("R10 no cfg data", rdata, 0);
    idle();
    bus_write(24'hE80048, 4'h7);
    bus_read(24'h21FFFE);
    chk("R10 base locked", card_sel, 1);
    idle();

    // R9 shut-up
    do_reset();
    #1;
    chk("R1 chain after reset", cfg_out_n, 1);
    bus_write(24'hE8004C, 4'h0);
    chk("R9 chain released", cfg_out_n, 0);
    bus_read(24'hE80000);
    chk("R9 no cfg answer", slave_n, 1);
    idle();
    bus_read(24'h000000);
    chk("R9 no window base0", card_sel, 0);
    chk("R9 no slave base0", slave_n, 1);
    idle();
    chk("R1 dtack held", dtack_n, 1);

    finish_run();
  end
endmodule